// File: doc/BRIEF.md
# Two-Step Unlocked Register Commit Sequencer

This block guards the clock and control registers of a timekeeping device against stray writes. A bus slave decodes each serial transfer into events: a byte event that carries a register address and data, a stop event and an abort event. The block collects the register bytes of the transfer in a small buffer and does not forward them straight away. The bytes reach the counter or nonvolatile registers only when the transfer ends with a clean stop and a two-step unlock is already in place.

The unlock is held in a status register at a fixed address. A host first writes one code there to set a write-enable flag. It then writes a second code to set a register-write flag, and that second code works only if the first flag is already set. A third code clears both flags. Status writes are applied at the stop of their transfer, just as register writes are.

After a commit, the block streams the buffered bytes out one per cycle. It then stays busy for a programmable number of cycles to stand in for the nonvolatile programming time. No other commit can start while it is busy.

Top module: `wp_commit_seq`

## Requirements
- R1: After reset, `wel`, `rwel`, `busy` and `commit_vld` are all 0.
- R2: At a clean stop, a transfer whose last status byte (address `STAT_ADDR`) was 02h sets `wel` to 1 and `rwel` to 0. The new values are visible in the cycle after the stop.
- R3: A status value of 06h at a clean stop sets `rwel` only if `wel` was already 1, and then leaves `wel` at 1. If `wel` was 0, both flags stay as they were. `rwel` never reads 1 while `wel` reads 0.
- R4: A status value of 00h at a clean stop clears both flags. Any status value other than 00h, 02h or 06h leaves both flags unchanged.
- R5: Register bytes (any address other than `STAT_ADDR`) are held back and committed only at a clean stop, and only when `rwel` was 1 before that stop. The commit starts in the cycle after the stop and presents one byte per cycle on `commit_vld`, `commit_addr` and `commit_data`, in arrival order.
- R6: An abort discards the buffered register bytes and any pending status byte. Nothing is committed and `wel`/`rwel` keep their values. If abort and stop arrive in the same cycle, the abort wins.
- R7: Register bytes beyond the first `DEPTH` of a transfer are dropped. A byte event in the same cycle as a stop or abort is ignored.
- R8: For a commit of n bytes, `busy` is 1 for exactly n + `BUSY_CYC` cycles, starting the cycle after the stop. A stop that arrives while `busy` is 1 commits nothing. A transfer that had a register byte arrive while the commit was streaming commits nothing at its stop.
- R9: A clean stop with no buffered register bytes produces no `commit_vld` pulse and leaves `busy` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| ev_addr | input | AW | Register address of the byte event |
| ev_data | input | 8 | Data byte of the byte event |
| ev_byte | input | 1 | A complete data byte was received this cycle |
| ev_stop | input | 1 | The transfer ended with a valid stop |
| ev_abort | input | 1 | The transfer broke off or ended with an incomplete byte |
| commit_vld | output | 1 | A committed byte is presented this cycle |
| commit_addr | output | AW | Address of the committed byte |
| commit_data | output | 8 | Data of the committed byte |
| busy | output | 1 | A commit is streaming or its programming window is open |
| wel | output | 1 | Write-enable flag |
| rwel | output | 1 | Register-write flag |

## Verification
The bench builds the block with `DEPTH` = 4 and `BUSY_CYC` = 6, and leaves the status address at 63. A buffer of four bytes lets a five-byte transfer hit the overflow drop, and the same transfer fills the buffer and streams it out completely. A six-cycle programming window is short enough to walk through cycle by cycle. That window has room for a whole second transfer to arrive and stop while the block is still busy. It also has room for bytes that arrive during the stream and after it, inside one transfer, to check the discard rule.

// File: rtl/wpl_pkg.sv
package wpl_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_DRAIN = 2'd1,
    SEQ_HOLD  = 2'd2
  } seq_state_e;

  localparam logic [7:0] CODE_CLEAR = 8'h00;
  localparam logic [7:0] CODE_WEL   = 8'h02;
  localparam logic [7:0] CODE_RWEL  = 8'h06;

endpackage

// File: rtl/wpl_latch.sv
module wpl_latch
  import wpl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stat_wr,
  input  logic [7:0] stat_val,
  input  logic       apply,
  input  logic       drop,
  output logic       wel,
  output logic       rwel
);

  logic       pend_q, pend_d;
  logic [7:0] val_q, val_d;
  logic       wel_q, wel_d;
  logic       rwel_q, rwel_d;

  always_comb begin
    pend_d = pend_q;
    val_d  = val_q;
    wel_d  = wel_q;
    rwel_d = rwel_q;
    if (apply || drop) begin
      pend_d = 1'b0;
    end else if (stat_wr) begin
      pend_d = 1'b1;
      val_d  = stat_val;
    end
    if (apply && pend_q) begin
      unique case (val_q)
        CODE_CLEAR: begin
          wel_d  = 1'b0;
          rwel_d = 1'b0;
        end
        CODE_WEL: begin
          wel_d  = 1'b1;
          rwel_d = 1'b0;
        end
        CODE_RWEL: begin
          if (wel_q) rwel_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      wel_q  <= wel_d;
      rwel_q <= rwel_d;
    end
  end

  always_ff @(posedge clk) begin
    if (stat_wr) val_q <= val_d;
  end

  assign wel  = wel_q;
  assign rwel = rwel_q;

endmodule

// File: rtl/wpl_buffer.sv
module wpl_buffer #(
  parameter int AW    = 8,
  parameter int DEPTH = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          clr,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [CW-1:0] count,
  output logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          full;
  logic          take;
  logic [AW-1:0] ent_a [DEPTH];
  logic [7:0]    ent_d [DEPTH];

  assign full = (cnt_q == CW'(DEPTH));
  assign take = wr_req && !full;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (take) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic hit;
    assign hit = take && (cnt_q == CW'(g));
    always_ff @(posedge clk) begin
      if (hit) begin
        ent_a[g] <= wr_addr;
        ent_d[g] <= wr_data;
      end
    end
  end

  assign count   = cnt_q;
  assign rd_addr = ent_a[rd_idx];
  assign rd_data = ent_d[rd_idx];

endmodule

// File: rtl/wpl_drain.sv
module wpl_drain
  import wpl_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int BUSY_CYC = 20,
  localparam int IW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int BW      = $clog2(BUSY_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [CW-1:0] n_in,
  output logic [IW-1:0] rd_idx,
  output logic          draining,
  output logic          busy
);

  seq_state_e    st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [CW-1:0] n_q, n_d;
  logic [BW-1:0] bc_q, bc_d;
  logic          last;

  assign last = (CW'(idx_q) + CW'(1)) == n_q;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    n_d   = n_q;
    bc_d  = bc_q;
    unique case (st_q)
      SEQ_IDLE: begin
        if (go) begin
          st_d  = SEQ_DRAIN;
          idx_d = '0;
          n_d   = n_in;
        end
      end
      SEQ_DRAIN: begin
        if (last) begin
          st_d = SEQ_HOLD;
          bc_d = BW'(BUSY_CYC);
        end else begin
          idx_d = idx_q + IW'(1);
        end
      end
      SEQ_HOLD: begin
        if (bc_q == BW'(1)) st_d = SEQ_IDLE;
        else                bc_d = bc_q - BW'(1);
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      idx_q <= '0;
      n_q   <= '0;
      bc_q  <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      n_q   <= n_d;
      bc_q  <= bc_d;
    end
  end

  assign rd_idx   = idx_q;
  assign draining = (st_q == SEQ_DRAIN);
  assign busy     = (st_q != SEQ_IDLE);

endmodule

// File: rtl/wp_commit_seq.sv
module wp_commit_seq #(
  parameter int AW        = 8,
  parameter int DEPTH     = 8,
  parameter int BUSY_CYC  = 20,
  parameter int STAT_ADDR = 63,
  localparam int IW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ev_addr,
  input  logic [7:0]    ev_data,
  input  logic          ev_byte,
  input  logic          ev_stop,
  input  logic          ev_abort,
  output logic          commit_vld,
  output logic [AW-1:0] commit_addr,
  output logic [7:0]    commit_data,
  output logic          busy,
  output logic          wel,
  output logic          rwel
);

  logic          byte_ok, is_stat, to_stat, to_reg;
  logic          stop_ok, xfer_end;
  logic          spoil_q, spoil_d;
  logic          draining, go;
  logic [CW-1:0] count;
  logic [IW-1:0] rd_idx;

  assign byte_ok  = ev_byte && !ev_stop && !ev_abort;
  assign is_stat  = (ev_addr == AW'(STAT_ADDR));
  assign to_stat  = byte_ok && is_stat;
  assign to_reg   = byte_ok && !is_stat;
  assign stop_ok  = ev_stop && !ev_abort;
  assign xfer_end = ev_stop || ev_abort;

  always_comb begin
    spoil_d = spoil_q;
    if (xfer_end)                spoil_d = 1'b0;
    else if (to_reg && draining) spoil_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spoil_q <= 1'b0;
    else        spoil_q <= spoil_d;
  end

  assign go = stop_ok && rwel && !spoil_q && !busy && (count != '0);

  wpl_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_wr  (to_stat),
    .stat_val (ev_data),
    .apply    (stop_ok),
    .drop     (ev_abort),
    .wel      (wel),
    .rwel     (rwel)
  );

  wpl_buffer #(.AW(AW), .DEPTH(DEPTH)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (to_reg && !draining),
    .clr     (xfer_end),
    .wr_addr (ev_addr),
    .wr_data (ev_data),
    .rd_idx  (rd_idx),
    .count   (count),
    .rd_addr (commit_addr),
    .rd_data (commit_data)
  );

  wpl_drain #(.DEPTH(DEPTH), .BUSY_CYC(BUSY_CYC)) u_drain (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .n_in     (count),
    .rd_idx   (rd_idx),
    .draining (draining),
    .busy     (busy)
  );

  assign commit_vld = draining;

endmodule

// File: rtl/wpl_chk.sv
module wpl_chk (
  input logic clk,
  input logic rst_n,
  input logic ev_stop,
  input logic ev_abort,
  input logic commit_vld,
  input logic busy,
  input logic wel,
  input logic rwel
);

  assert_rwel_implies_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rwel |-> wel);

  assert_rwel_rise_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rwel) |-> $past(wel));

  assert_wel_set_at_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(ev_stop));

  assert_commit_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(commit_vld) |-> ($past(ev_stop) && !$past(ev_abort)));

  assert_commit_inside_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_vld |-> busy);

  assert_abort_no_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_abort && !busy) |=> !commit_vld);

endmodule

bind wp_commit_seq wpl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_stop    (ev_stop),
  .ev_abort   (ev_abort),
  .commit_vld (commit_vld),
  .busy       (busy),
  .wel        (wel),
  .rwel       (rwel)
);

// File: tb/sim_wp_commit_seq.sv
module sim_wp_commit_seq;

  localparam int D  = 4;
  localparam int B  = 6;
  localparam int SA = 63;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ev_addr = '0;
  logic [7:0] ev_data = '0;
  logic       ev_byte = 1'b0;
  logic       ev_stop = 1'b0;
  logic       ev_abort = 1'b0;
  logic       commit_vld;
  logic [7:0] commit_addr;
  logic [7:0] commit_data;
  logic       busy, wel, rwel;

  always #2.5 clk = ~clk;

  wp_commit_seq #(.AW(8), .DEPTH(D), .BUSY_CYC(B), .STAT_ADDR(SA)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_addr(ev_addr), .ev_data(ev_data),
    .ev_byte(ev_byte), .ev_stop(ev_stop), .ev_abort(ev_abort),
    .commit_vld(commit_vld), .commit_addr(commit_addr), .commit_data(commit_data),
    .busy(busy), .wel(wel), .rwel(rwel)
  );

  int n_chk = 0;
  int n_bad = 0;

  bit       m_wel, m_rwel, m_has, m_spoil;
  bit [7:0] m_stat;
  int       m_cnt;
  bit [7:0] m_a [D];
  bit [7:0] m_d [D];

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit [1:0] lat_next(input bit w, input bit r, input bit has, input bit [7:0] v);
    if (!has) return {w, r};
    case (v)
      8'h00: return 2'b00;
      8'h02: return 2'b10;
      8'h06: return w ? 2'b11 : {w, r};
      default: return {w, r};
    endcase
  endfunction

  function automatic bit [7:0] reg_addr(input bit [7:0] a);
    return (a == 8'(SA)) ? (a ^ 8'h01) : a;
  endfunction

  task automatic clear_model();
    m_has = 0; m_cnt = 0; m_spoil = 0;
  endtask

  task automatic send_byte(input bit [7:0] a, input bit [7:0] d);
    ev_addr = a; ev_data = d; ev_byte = 1'b1;
    if (a == 8'(SA)) begin
      m_has = 1; m_stat = d;
    end else if (m_cnt < D) begin
      m_a[m_cnt] = a; m_d[m_cnt] = d; m_cnt++;
    end
    @(negedge clk);
    ev_byte = 1'b0;
  endtask

  task automatic expect_commit(input int n);
    if (n == 0) begin
      chk("R9", "busy after empty stop", busy, 0);
      chk("R9", "commit_vld after empty stop", commit_vld, 0);
    end else begin
      for (int k = 0; k < n + B; k++) begin
        chk("R8", "busy window", busy, 1);
        if (k < n) begin
          chk("R5", "commit_vld", commit_vld, 1);
          chk("R5", "commit_addr", commit_addr, m_a[k]);
          chk("R5", "commit_data", commit_data, m_d[k]);
        end else begin
          chk("R8", "commit_vld after stream", commit_vld, 0);
        end
        @(negedge clk);
      end
      chk("R8", "busy released", busy, 0);
    end
  endtask

  task automatic send_stop(input bit with_byte);
    int n;
    bit [1:0] nl;
    ev_stop = 1'b1;
    if (with_byte) begin
      ev_byte = 1'b1; ev_addr = 8'h20; ev_data = 8'hEE;
    end
    n = (m_rwel && !m_spoil) ? m_cnt : 0;
    nl = lat_next(m_wel, m_rwel, m_has, m_stat);
    m_wel = nl[1]; m_rwel = nl[0];
    @(negedge clk);
    ev_stop = 1'b0; ev_byte = 1'b0;
    chk("R2", "wel after stop", wel, m_wel);
    chk("R3", "rwel after stop", rwel, m_rwel);
    expect_commit(n);
    clear_model();
  endtask

  task automatic send_abort();
    ev_abort = 1'b1;
    @(negedge clk);
    ev_abort = 1'b0;
    clear_model();
    chk("R6", "wel after abort", wel, m_wel);
    chk("R6", "rwel after abort", rwel, m_rwel);
    chk("R6", "commit_vld after abort", commit_vld, 0);
    chk("R6", "busy after abort", busy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_wel = 0; m_rwel = 0; m_stat = 0;
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "wel", wel, 0);
    chk("R1", "rwel", rwel, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "commit_vld", commit_vld, 0);

    // R5: locked, nothing committed
    send_byte(8'h01, 8'h11);
    send_stop(0);
    // R3: 06h without wel
    send_byte(8'(SA), 8'h06);
    send_stop(0);
    // R2, R3: unlock in two steps
    send_byte(8'(SA), 8'h02);
    send_stop(0);
    send_byte(8'(SA), 8'h06);
    send_stop(0);
    // R7 overflow: five bytes, four committed
    for (int i = 0; i < 5; i++) send_byte(8'(i + 2), 8'(8'hA0 + i));
    send_stop(0);
    // R7: byte coincident with stop ignored
    send_byte(8'h09, 8'h3C);
    send_stop(1);

    // R8: stop during busy window commits nothing
    send_byte(8'h10, 8'hA5);
    ev_stop = 1'b1;
    @(negedge clk);
    ev_stop = 1'b0;
    chk("R5", "commit_vld first", commit_vld, 1);
    chk("R5", "commit_data first", commit_data, 8'hA5);
    clear_model();
    @(negedge clk);
    send_byte(8'h11, 8'h5A);
    ev_stop = 1'b1;
    @(negedge clk);
    ev_stop = 1'b0;
    clear_model();
    for (int k = 4; k <= 7; k++) begin
      chk("R8", "busy while blocked", busy, 1);
      chk("R8", "no commit while busy", commit_vld, 0);
      @(negedge clk);
    end
    chk("R8", "busy end", busy, 0);
    chk("R8", "rwel kept", rwel, 1);

    // R8: byte during stream spoils the next transfer
    for (int i = 0; i < D; i++) send_byte(8'(8'h30 + i), 8'(8'h70 + i));
    ev_stop = 1'b1;
    @(negedge clk);
    ev_stop = 1'b0;
    clear_model();
    send_byte(8'h40, 8'h01);
    while (busy) @(negedge clk);
    send_byte(8'h41, 8'h02);
    m_spoil = 1;
    send_stop(0);
    // spoil cleared: clean transfer commits
    send_byte(8'h42, 8'hC3);
    send_stop(0);

    // R6: abort discards bytes and status
    send_byte(8'h05, 8'h99);
    send_byte(8'(SA), 8'h00);
    send_abort();
    send_stop(0);
    // R4: other code ignored, 00h clears
    send_byte(8'(SA), 8'h55);
    send_stop(0);
    chk("R4", "wel after 55h", wel, 1);
    send_byte(8'(SA), 8'h00);
    send_stop(0);
    chk("R4", "wel after 00h", wel, 0);
    chk("R4", "rwel after 00h", rwel, 0);

    // random transfers
    for (int t = 0; t < 60; t++) begin
      int len;
      len = $urandom_range(0, D + 1);
      for (int i = 0; i < len; i++) begin
        if ($urandom_range(0, 3) == 0) begin
          int c;
          bit [7:0] v;
          c = $urandom_range(0, 5);
          v = (c < 2) ? 8'h02 : (c < 4) ? 8'h06 : (c == 4) ? 8'h00 : 8'($urandom);
          send_byte(8'(SA), v);
        end else begin
          send_byte(reg_addr(8'($urandom)), 8'($urandom));
        end
      end
      if ($urandom_range(0, 6) == 0) send_abort();
      else send_stop(0);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule